// File: doc/BRIEF.md
# SRAM Sleep-Mode Power-Down Sequencer

This block stands between a synchronous pipelined SRAM's command inputs and its core. It watches an asynchronous, active-high sleep request pin. When the request is seen, the block does not cut power at once. It walks through a counted entry window, then an asleep state, and on release a counted recovery window. While asleep, every command is blocked and the data-bus output enable is forced low, so the bus floats.

During the entry and recovery windows only deselect and read commands reach the core. Any write is dropped and reported with a one-cycle error pulse. When the request arrives while commands accepted in the last few cycles may still be inside the pipeline, a warning pulse is raised, because such operations are not guaranteed to finish.

The request pin first passes through a flip-flop synchroniser. All windows are counted in clock cycles after synchronisation. A command is encoded by two bits: `cmd_valid`=0 is a deselect, `cmd_valid`=1 with `cmd_write`=0 is a read, and `cmd_valid`=1 with `cmd_write`=1 is a write.

Top module: `sram_sleep_seq`

## Requirements
- R1: Reset (active-low `rst_n`, asynchronous) puts the block in the awake state, with `in_sleep`=0, `wr_err`=0 and `pend_warn`=0.
- R2: `sleep_pin` passes through SYNC_STAGES (default 2) flip-flops. A rise of the pin held stable before clock edge 1 moves the block out of awake at edge SYNC_STAGES+1, so that from this edge on, writes no longer reach `cmd_write_o`.
- R3: If the synchronised request stays high, the block spends ENTRY_CYCLES (default 2) cycles in the entry window and then becomes asleep. `in_sleep`=1 exactly while asleep.
- R4: While asleep, `cmd_valid_o`=0, `cmd_write_o`=0 and `dq_oe`=0, whatever the command and `oe_req` inputs are.
- R5: In the entry and recovery windows, a read is passed (`cmd_valid_o`=1, `cmd_write_o`=0), a deselect is passed as a deselect, and a write is blocked (`cmd_valid_o`=0, `cmd_write_o`=0). `dq_oe` follows `oe_req`.
- R6: `wr_err` is high for exactly the one cycle that follows each cycle in which a write is presented during the entry or recovery window. It is low at all other times.
- R7: After the synchronised request falls in the asleep state, the block spends RECOVER_CYCLES (default 2) cycles in the recovery window and then returns to awake. A request that rises again during recovery is acted on only after the recovery has finished.
- R8: If the synchronised request falls during the entry window, the block goes straight to the recovery window and runs the full RECOVER_CYCLES count. It never becomes asleep on that request.
- R9: `pend_warn` pulses for one cycle, together with the first cycle of the entry window. It does so when a command was accepted in the last awake cycle or in any of the PIPE_DEPTH (default 2) cycles before it. If no command was accepted in that span, it stays low.
- R10: While awake, `cmd_valid_o`, `cmd_write_o` and `dq_oe` equal `cmd_valid`, `cmd_valid`&`cmd_write` and `oe_req`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sleep_pin | input | 1 | Asynchronous active-high sleep request |
| cmd_valid | input | 1 | Command present (0 = deselect) |
| cmd_write | input | 1 | Command is a write when valid |
| oe_req | input | 1 | Core's request to drive the data bus |
| cmd_valid_o | output | 1 | Gated command-present to the core |
| cmd_write_o | output | 1 | Gated write to the core |
| dq_oe | output | 1 | Data-bus output enable (0 = high impedance) |
| in_sleep | output | 1 | High while in the low-current asleep state |
| wr_err | output | 1 | One-cycle pulse for a write seen in a window |
| pend_warn | output | 1 | One-cycle pulse: sleep requested with operations in flight |

## Verification
The assertions check the following on every cycle:
- the asleep state is entered only from a complete entry window, and awake is re-entered only after a complete recovery count;
- the block is silent while asleep, and no write leaks through in a window;
- every error and warning pulse has a legal cause.

Some behaviour only the bench scenarios can show: the exact edge at which the synchronised pin changes state, the abort from the entry window that never sleeps, a re-request during recovery being deferred, and the presence or absence of the warning depending on recent traffic. The bench shows these by comparing every output each cycle with a behavioural model.

// File: rtl/sram_sleep_pkg.sv
package sram_sleep_pkg;
   typedef enum logic [1:0] {
      SLP_AWAKE   = 2'd0,
      SLP_ENTER   = 2'd1,
      SLP_ASLEEP  = 2'd2,
      SLP_RECOVER = 2'd3
   } slp_state_e;
endpackage

// File: rtl/slp_sync.sv
module slp_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_async,
   output logic q_sync
);
   logic [STAGES-1:0] chain_q;

   generate
      if (STAGES == 1) begin : g_single
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= '0;
            else        chain_q <= d_async;
         end
      end else begin : g_chain
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= '0;
            else        chain_q <= {chain_q[STAGES-2:0], d_async};
         end
      end
   endgenerate

   assign q_sync = chain_q[STAGES-1];
endmodule

// File: rtl/slp_fsm.sv
module slp_fsm
   import sram_sleep_pkg::*;
#(
   parameter int ENTRY_CYCLES   = 2,
   parameter int RECOVER_CYCLES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       req_s,
   output slp_state_e state_o
);
   localparam int MAX_CYC = (ENTRY_CYCLES > RECOVER_CYCLES) ? ENTRY_CYCLES : RECOVER_CYCLES;
   localparam int CNT_W   = (MAX_CYC < 2) ? 1 : $clog2(MAX_CYC);
   localparam logic [CNT_W-1:0] ENTRY_LAST = CNT_W'(ENTRY_CYCLES - 1);
   localparam logic [CNT_W-1:0] REC_LAST   = CNT_W'(RECOVER_CYCLES - 1);

   slp_state_e       st_q, st_d;
   logic [CNT_W-1:0] cnt_q, cnt_d;

   always_comb begin
      st_d  = st_q;
      cnt_d = cnt_q;
      unique case (st_q)
         SLP_AWAKE: begin
            if (req_s) begin
               st_d  = SLP_ENTER;
               cnt_d = '0;
            end
         end
         SLP_ENTER: begin
            if (!req_s) begin
               st_d  = SLP_RECOVER;
               cnt_d = '0;
            end else if (cnt_q == ENTRY_LAST) begin
               st_d  = SLP_ASLEEP;
               cnt_d = '0;
            end else begin
               cnt_d = cnt_q + 1'b1;
            end
         end
         SLP_ASLEEP: begin
            if (!req_s) begin
               st_d  = SLP_RECOVER;
               cnt_d = '0;
            end
         end
         SLP_RECOVER: begin
            if (cnt_q == REC_LAST) begin
               st_d  = SLP_AWAKE;
               cnt_d = '0;
            end else begin
               cnt_d = cnt_q + 1'b1;
            end
         end
         default: begin
            st_d  = SLP_AWAKE;
            cnt_d = '0;
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= SLP_AWAKE;
         cnt_q <= '0;
      end else begin
         st_q  <= st_d;
         cnt_q <= cnt_d;
      end
   end

   assign state_o = st_q;

   AST_ASLEEP_AFTER_FULL_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == SLP_ASLEEP && $past(st_q) != SLP_ASLEEP) |->
         ($past(st_q) == SLP_ENTER && $past(cnt_q) == ENTRY_LAST)); // R3
   AST_AWAKE_AFTER_FULL_RECOVERY: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == SLP_AWAKE && $past(st_q) == SLP_RECOVER) |-> ($past(cnt_q) == REC_LAST)); // R7
   AST_ENTRY_ABORT_TO_RECOVER: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == SLP_ENTER && !req_s) |=> (st_q == SLP_RECOVER && cnt_q == '0)); // R8
endmodule

// File: rtl/slp_cmd_gate.sv
module slp_cmd_gate
   import sram_sleep_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  slp_state_e state_i,
   input  logic       cmd_valid,
   input  logic       cmd_write,
   input  logic       oe_req,
   output logic       cmd_valid_o,
   output logic       cmd_write_o,
   output logic       dq_oe,
   output logic       wr_err
);
   logic awake, window, asleep, bad_wr;
   logic err_q;

   assign awake  = (state_i == SLP_AWAKE);
   assign asleep = (state_i == SLP_ASLEEP);
   assign window = (state_i == SLP_ENTER) || (state_i == SLP_RECOVER);
   assign bad_wr = window && cmd_valid && cmd_write;

   assign cmd_valid_o = cmd_valid && (awake || (window && !cmd_write));
   assign cmd_write_o = cmd_valid && cmd_write && awake;
   assign dq_oe       = oe_req && !asleep;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) err_q <= 1'b0;
      else        err_q <= bad_wr;
   end

   assign wr_err = err_q;

   AST_ERR_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      wr_err |-> $past(cmd_valid && cmd_write && state_i != SLP_AWAKE && state_i != SLP_ASLEEP)); // R6
endmodule

// File: rtl/slp_pend_track.sv
module slp_pend_track
   import sram_sleep_pkg::*;
#(
   parameter int PIPE_DEPTH = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  slp_state_e state_i,
   input  logic       req_s,
   input  logic       accepted,
   output logic       pend_warn
);
   logic [PIPE_DEPTH-1:0] inflight_q;
   logic                  warn_q;
   logic                  busy;

   generate
      if (PIPE_DEPTH == 1) begin : g_one
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) inflight_q <= '0;
            else        inflight_q <= accepted;
         end
      end else begin : g_shift
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) inflight_q <= '0;
            else        inflight_q <= {inflight_q[PIPE_DEPTH-2:0], accepted};
         end
      end
   endgenerate

   assign busy = (|inflight_q) || accepted;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) warn_q <= 1'b0;
      else        warn_q <= (state_i == SLP_AWAKE) && req_s && busy;
   end

   assign pend_warn = warn_q;

   AST_WARN_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      pend_warn |=> !pend_warn); // R9
endmodule

// File: rtl/sram_sleep_seq.sv
module sram_sleep_seq
   import sram_sleep_pkg::*;
#(
   parameter int SYNC_STAGES    = 2,
   parameter int ENTRY_CYCLES   = 2,
   parameter int RECOVER_CYCLES = 2,
   parameter int PIPE_DEPTH     = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sleep_pin,
   input  logic cmd_valid,
   input  logic cmd_write,
   input  logic oe_req,
   output logic cmd_valid_o,
   output logic cmd_write_o,
   output logic dq_oe,
   output logic in_sleep,
   output logic wr_err,
   output logic pend_warn
);
   initial begin
      if (SYNC_STAGES < 2)    $error("SYNC_STAGES must be at least 2");
      if (ENTRY_CYCLES < 1)   $error("ENTRY_CYCLES must be at least 1");
      if (RECOVER_CYCLES < 1) $error("RECOVER_CYCLES must be at least 1");
      if (PIPE_DEPTH < 1)     $error("PIPE_DEPTH must be at least 1");
   end

   logic       req_s;
   slp_state_e state;

   slp_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .d_async (sleep_pin),
      .q_sync  (req_s)
   );

   slp_fsm #(.ENTRY_CYCLES(ENTRY_CYCLES), .RECOVER_CYCLES(RECOVER_CYCLES)) u_fsm (
      .clk     (clk),
      .rst_n   (rst_n),
      .req_s   (req_s),
      .state_o (state)
   );

   slp_cmd_gate u_gate (
      .clk         (clk),
      .rst_n       (rst_n),
      .state_i     (state),
      .cmd_valid   (cmd_valid),
      .cmd_write   (cmd_write),
      .oe_req      (oe_req),
      .cmd_valid_o (cmd_valid_o),
      .cmd_write_o (cmd_write_o),
      .dq_oe       (dq_oe),
      .wr_err      (wr_err)
   );

   slp_pend_track #(.PIPE_DEPTH(PIPE_DEPTH)) u_pend (
      .clk       (clk),
      .rst_n     (rst_n),
      .state_i   (state),
      .req_s     (req_s),
      .accepted  (cmd_valid_o),
      .pend_warn (pend_warn)
   );

   assign in_sleep = (state == SLP_ASLEEP);

   AST_ASLEEP_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      in_sleep |-> (!cmd_valid_o && !cmd_write_o && !dq_oe)); // R4
   AST_WINDOW_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (state == SLP_ENTER || state == SLP_RECOVER) |-> !cmd_write_o); // R5
   AST_WARN_IN_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
      pend_warn |-> (state == SLP_ENTER && $past(state) == SLP_AWAKE)); // R9
   AST_AWAKE_PASS: assert property (@(posedge clk) disable iff (!rst_n)
      (state == SLP_AWAKE) |-> (cmd_write_o == (cmd_valid && cmd_write) && dq_oe == oe_req)); // R10
endmodule

// File: tb/sram_sleep_seq_bench.sv
module sram_sleep_seq_bench;
   localparam int CLK_PERIOD = 10;
   localparam int SYNC  = 2;
   localparam int ENTRY = 2;
   localparam int REC   = 2;
   localparam int PIPE  = 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic sleep_pin = 1'b0, cmd_valid = 1'b0, cmd_write = 1'b0, oe_req = 1'b0;
   logic cmd_valid_o, cmd_write_o, dq_oe, in_sleep, wr_err, pend_warn;

   int checks = 0;
   int errors = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   sram_sleep_seq #(.SYNC_STAGES(SYNC), .ENTRY_CYCLES(ENTRY),
                    .RECOVER_CYCLES(REC), .PIPE_DEPTH(PIPE)) u_sram_sleep_seq (
      .clk(clk), .rst_n(rst_n), .sleep_pin(sleep_pin), .cmd_valid(cmd_valid),
      .cmd_write(cmd_write), .oe_req(oe_req), .cmd_valid_o(cmd_valid_o),
      .cmd_write_o(cmd_write_o), .dq_oe(dq_oe), .in_sleep(in_sleep),
      .wr_err(wr_err), .pend_warn(pend_warn)
   );

   // Behavioural reference: pin history queue, phase number 0 awake,
   // 1 entry, 2 asleep, 3 recovery; acceptance history queue.
   int pin_hist[$];
   int acc_hist[$];
   int m_ph = 0, m_cnt = 0, m_err = 0, m_warn = 0;
   int m_acc, m_busy, m_req, m_nph, m_ncnt;

   function automatic int exp_valid();
      if (m_ph == 2) return 0;
      if (m_ph == 0) return int'(cmd_valid);
      return int'(cmd_valid && !cmd_write);
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         pin_hist = {};
         acc_hist = {};
         for (int i = 0; i < SYNC; i++) pin_hist.push_back(0);
         for (int i = 0; i < PIPE; i++) acc_hist.push_back(0);
         m_ph = 0; m_cnt = 0; m_err = 0; m_warn = 0;
      end else begin
         m_req  = pin_hist[0];
         m_acc  = exp_valid();
         m_busy = (acc_hist.sum() != 0 || m_acc != 0) ? 1 : 0;
         m_err  = ((m_ph == 1 || m_ph == 3) && cmd_valid && cmd_write) ? 1 : 0;
         m_warn = (m_ph == 0 && m_req != 0 && m_busy != 0) ? 1 : 0;
         m_nph = m_ph; m_ncnt = m_cnt;
         if (m_ph == 0) begin
            if (m_req != 0) begin m_nph = 1; m_ncnt = 0; end
         end else if (m_ph == 1) begin
            if (m_req == 0) begin m_nph = 3; m_ncnt = 0; end
            else if (m_cnt == ENTRY - 1) begin m_nph = 2; m_ncnt = 0; end
            else m_ncnt = m_cnt + 1;
         end else if (m_ph == 2) begin
            if (m_req == 0) begin m_nph = 3; m_ncnt = 0; end
         end else begin
            if (m_cnt == REC - 1) begin m_nph = 0; m_ncnt = 0; end
            else m_ncnt = m_cnt + 1;
         end
         m_ph = m_nph; m_cnt = m_ncnt;
         void'(pin_hist.pop_front());
         pin_hist.push_back(int'(sleep_pin));
         void'(acc_hist.pop_front());
         acc_hist.push_back(m_acc);
      end
   end

   task automatic chk(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
      end
   endtask

   task automatic compare_all();
      string tg;
      tg = (m_ph == 2) ? "R4" : ((m_ph == 0) ? "R10" : "R5");
      chk(tg, "cmd_valid_o", int'(cmd_valid_o), exp_valid());
      chk(tg, "cmd_write_o", int'(cmd_write_o), (m_ph == 0) ? int'(cmd_valid && cmd_write) : 0);
      chk((m_ph == 2) ? "R4" : "R10", "dq_oe", int'(dq_oe), (m_ph == 2) ? 0 : int'(oe_req));
      chk("R3", "in_sleep", int'(in_sleep), (m_ph == 2) ? 1 : 0);
      chk("R6", "wr_err", int'(wr_err), m_err);
      chk("R9", "pend_warn", int'(pend_warn), m_warn);
   endtask

   task automatic step(input logic v, input logic w, input logic oe, input logic pin);
      @(negedge clk);
      cmd_valid = v; cmd_write = w; oe_req = oe; sleep_pin = pin;
      #1;
      compare_all();
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      int first, warns;
      repeat (3) @(negedge clk);
      // R1: reset state
      chk("R1", "in_sleep in reset", int'(in_sleep), 0);
      chk("R1", "wr_err in reset", int'(wr_err), 0);
      chk("R1", "pend_warn in reset", int'(pend_warn), 0);
      rst_n = 1'b1;
      for (int i = 0; i < 8; i++) step(1'b1, i[0], 1'b1, 1'b0);

      // R2/R3: entry timing with writes presented on every cycle
      for (int i = 0; i < 6; i++) step(1'b0, 1'b0, 1'b0, 1'b0);
      step(1'b1, 1'b1, 1'b1, 1'b1);
      first = -1;
      for (int i = 1; i <= 8; i++) begin
         step(1'b1, 1'b1, 1'b1, 1'b1);
         if (i == SYNC) chk("R2", "write passes before sync edge", int'(cmd_write_o), 1);
         if (i == SYNC + 1) chk("R2", "write blocked after sync edge", int'(cmd_write_o), 0);
         if (i == SYNC + 2) chk("R6", "error pulse in entry", int'(wr_err), 1);
         if (in_sleep && first < 0) first = i;
      end
      chk("R3", "cycles to asleep", first, SYNC + 1 + ENTRY);
      // R4: commands and output enable ignored while asleep
      for (int i = 0; i < 4; i++) begin
         step(1'b1, i[0], 1'b1, 1'b1);
         chk("R4", "asleep blocks command", int'(cmd_valid_o), 0);
         chk("R4", "asleep floats bus", int'(dq_oe), 0);
      end

      // R7: recovery timing with writes held
      step(1'b1, 1'b1, 1'b0, 1'b0);
      first = -1;
      for (int i = 1; i <= 9; i++) begin
         step(1'b1, 1'b1, 1'b0, (i == SYNC + 2) ? 1'b1 : 1'b0);
         if (cmd_write_o && first < 0) first = i;
      end
      chk("R7", "cycles to awake", first, SYNC + 1 + REC);

      // R8: short request aborts entry and never sleeps
      for (int i = 0; i < 10; i++) step(1'b0, 1'b0, 1'b0, 1'b0);
      step(1'b0, 1'b0, 1'b0, 1'b1);
      first = 0;
      for (int i = 0; i < 10; i++) begin
         step(1'b1, 1'b0, 1'b0, 1'b0);
         if (in_sleep) first = 1;
      end
      chk("R8", "abort never sleeps", first, 0);

      // R9: warning with recent read, none without traffic
      for (int i = 0; i < 6; i++) step(1'b0, 1'b0, 1'b0, 1'b0);
      step(1'b1, 1'b0, 1'b0, 1'b1);
      warns = 0;
      for (int i = 0; i < 8; i++) begin
         step(1'b0, 1'b0, 1'b0, 1'b1);
         warns += int'(pend_warn);
      end
      chk("R9", "warning with read in flight", warns, 1);
      for (int i = 0; i < 10; i++) step(1'b0, 1'b0, 1'b0, 1'b0);
      step(1'b0, 1'b0, 1'b0, 1'b1);
      warns = 0;
      for (int i = 0; i < 8; i++) begin
         step(1'b0, 1'b0, 1'b0, 1'b1);
         warns += int'(pend_warn);
      end
      chk("R9", "no warning when idle", warns, 0);

      // Mixed traffic with a slowly toggling pin, model compared each cycle
      for (int i = 0; i < 3000; i++) begin
         logic pin;
         pin = (($urandom % 12) == 0) ? ~sleep_pin : sleep_pin;
         step(1'($urandom), 1'($urandom), 1'($urandom), pin);
      end

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule